// File: doc/BRIEF.md
# Bit-Serial CRC-8 Frame Checker

This block folds a serial data stream into an 8-bit checksum one bit per clock. It sits beside a serial-to-parallel converter at the very first input stage of a receive channel, so that every word gets a checksum as it arrives. Logic further down the readout and transport path is unprotected against upsets. A checksum that is recomputed later and compared with this one exposes any corruption that happens in between. Each input channel has its own instance.

A frame begins with a start pulse, which clears the register to zero. Each bit that arrives with its valid strobe high is then shifted in, most significant bit first, using the generator x^8+x^2+x+1. After a parameterised number of accepted bits, the block raises a one-cycle completion strobe and presents the final checksum. If an expected checksum is supplied, the block also raises a mismatch flag together with the strobe when the two values differ.

Top module: `crc8_serial_chk`

## Requirements
- R1: While reset is high, and in the first cycle after it, `crc_o` is 0x00 and `done_o` and `mismatch_o` are 0.
- R2: An accepted bit updates the register as follows. The feedback is the bit XOR register bit 7. The register shifts left by one, and bits 0, 1 and 2 are XORed with the feedback (polynomial 0x07). The frame is sent MSB first from a start value of 0x00. Reference values for a 32-bit frame: 0x00000001 gives 0x07, 0x00000080 gives 0x89, 0x00000100 gives 0x15, 0x00000101 gives 0x12 and 0x00000181 gives 0x9B.
- R3: A start pulse with no valid bit sets `crc_o` to 0x00 on the next cycle and restarts the bit count. This also applies in the middle of a frame.
- R4: A cycle with `bit_vld_i` low leaves the register and the bit count unchanged, so idle gaps inside a frame do not change the result.
- R5: The cycle after the clock edge that takes the last bit of a frame, `done_o` is high for exactly one cycle. `crc_o` then holds the final checksum until the next start pulse.
- R6: `mismatch_o` is high only together with `done_o`. It is high exactly when `exp_vld_i` was high on the last bit's cycle and `exp_crc_i` differed from the final checksum.
- R7: Valid bits that arrive when no frame is open (after completion and before a start pulse) are ignored. `crc_o` stays unchanged and `done_o` stays low.
- R8: The frame length comes from `FRAME_BITS` (default 32). With `FRAME_BITS` set to 72, the ASCII string "123456789" gives 0xF4.
- R9: A start pulse in the same cycle as a valid bit clears the register and takes that bit as the frame's first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_i | input | 1 | Frame start pulse |
| bit_vld_i | input | 1 | Serial bit valid strobe |
| bit_i | input | 1 | Serial data bit, MSB first |
| exp_vld_i | input | 1 | Expected checksum is supplied |
| exp_crc_i | input | 8 | Expected checksum |
| crc_o | output | 8 | Running / final checksum (registered) |
| done_o | output | 1 | One-cycle frame completion strobe |
| mismatch_o | output | 1 | Final checksum differs from expected |

## Verification
The assertions check the following on every cycle:
- The register holds its value in idle cycles.
- A lone start pulse clears the register.
- The bit counter stays within the frame length.
- Completion follows an accepted bit.
- Mismatch occurs only with completion and with an expected value present.
- The checksum stays frozen after completion.

Only the bench scenarios can show the following:
- That the checksum values themselves are right: the hand-derived 32-bit words and the 72-bit check string.
- That gaps do not change the result.
- That a start pulse in mid-frame or together with a bit gives the expected value.

// File: rtl/crc8_pkg.sv
package crc8_pkg;
  localparam int CRC_W = 8;
  typedef logic [CRC_W-1:0] crc_t;
  localparam crc_t CRC_POLY_DEF = 8'h07;
  localparam crc_t CRC_INIT_DEF = 8'h00;
endpackage

// File: rtl/crc8_lfsr.sv
module crc8_lfsr
  import crc8_pkg::*;
#(
  parameter crc_t POLY = CRC_POLY_DEF,
  parameter crc_t INIT = CRC_INIT_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic shift_i,
  input  logic bit_i,
  output crc_t crc_o,
  output crc_t crc_nxt_o
);
  crc_t crc_q;
  crc_t base;
  crc_t stepped;
  logic fb;

  assign base = load_i ? INIT : crc_q;
  assign fb   = bit_i ^ base[CRC_W-1];

  for (genvar i = 0; i < CRC_W; i++) begin : g_tap
    if (i == 0) begin : g_lsb
      assign stepped[i] = POLY[i] & fb;
    end else begin : g_up
      assign stepped[i] = base[i-1] ^ (POLY[i] & fb);
    end
  end

  assign crc_nxt_o = stepped;

  always_ff @(posedge clk) begin
    if (rst)          crc_q <= INIT;
    else if (shift_i) crc_q <= stepped;
    else if (load_i)  crc_q <= INIT;
  end

  assign crc_o = crc_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !shift_i) |=> $stable(crc_q)); // R4
  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (load_i && !shift_i) |=> (crc_q == INIT)); // R3
endmodule

// File: rtl/crc8_frame_ctl.sv
module crc8_frame_ctl #(
  parameter int FRAME_BITS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic sof_i,
  input  logic bit_vld_i,
  output logic accept_o,
  output logic last_o,
  output logic done_o
);
  localparam int CW = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_BITS - 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_base;
  logic          done_q;

  assign cnt_base = sof_i ? '0 : cnt_q;
  assign accept_o = bit_vld_i & (active_q | sof_i);
  assign last_o   = accept_o & (cnt_base == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last_o;
      if (accept_o) begin
        if (last_o) begin
          active_q <= 1'b0;
          cnt_q    <= '0;
        end else begin
          active_q <= 1'b1;
          cnt_q    <= cnt_base + 1'b1;
        end
      end else if (sof_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end
    end
  end

  assign done_o = done_q;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    32'(cnt_q) < FRAME_BITS); // R5
  AST_DONE_AFTER_BIT: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(bit_vld_i)); // R5
endmodule

// File: rtl/crc8_cmp.sv
module crc8_cmp
  import crc8_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic last_i,
  input  crc_t crc_nxt_i,
  input  logic exp_vld_i,
  input  crc_t exp_crc_i,
  output logic mismatch_o
);
  logic mm_q;

  always_ff @(posedge clk) begin
    if (rst) mm_q <= 1'b0;
    else     mm_q <= last_i & exp_vld_i & (crc_nxt_i != exp_crc_i);
  end

  assign mismatch_o = mm_q;

  AST_MM_NEEDS_EXP: assert property (@(posedge clk) disable iff (rst)
    mm_q |-> $past(exp_vld_i)); // R6
endmodule

// File: rtl/crc8_serial_chk.sv
module crc8_serial_chk
  import crc8_pkg::*;
#(
  parameter int   FRAME_BITS = 32,
  parameter crc_t POLY       = CRC_POLY_DEF,
  parameter crc_t INIT       = CRC_INIT_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sof_i,
  input  logic             bit_vld_i,
  input  logic             bit_i,
  input  logic             exp_vld_i,
  input  logic [CRC_W-1:0] exp_crc_i,
  output logic [CRC_W-1:0] crc_o,
  output logic             done_o,
  output logic             mismatch_o
);
  logic accept;
  logic last;
  crc_t crc_nxt;
  crc_t crc_reg;

  crc8_frame_ctl #(.FRAME_BITS(FRAME_BITS)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .sof_i     (sof_i),
    .bit_vld_i (bit_vld_i),
    .accept_o  (accept),
    .last_o    (last),
    .done_o    (done_o)
  );

  crc8_lfsr #(.POLY(POLY), .INIT(INIT)) u_lfsr (
    .clk       (clk),
    .rst       (rst),
    .load_i    (sof_i),
    .shift_i   (accept),
    .bit_i     (bit_i),
    .crc_o     (crc_reg),
    .crc_nxt_o (crc_nxt)
  );

  crc8_cmp u_cmp (
    .clk        (clk),
    .rst        (rst),
    .last_i     (last),
    .crc_nxt_i  (crc_nxt),
    .exp_vld_i  (exp_vld_i),
    .exp_crc_i  (exp_crc_i),
    .mismatch_o (mismatch_o)
  );

  assign crc_o = crc_reg;

  AST_MM_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    mismatch_o |-> done_o); // R6
  AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (done_o && !sof_i) |=> $stable(crc_o)); // R7
endmodule

// File: tb/tb_crc8_serial_chk.sv
module tb_crc8_serial_chk;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sof = 1'b0;
  logic       vld = 1'b0;
  logic       din = 1'b0;
  logic       expv = 1'b0;
  logic [7:0] expc = 8'h00;
  logic [7:0] crc, crc72;
  logic       done, done72, mm, mm72;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  crc8_serial_chk dut (
    .clk(clk), .rst(rst), .sof_i(sof), .bit_vld_i(vld), .bit_i(din),
    .exp_vld_i(expv), .exp_crc_i(expc),
    .crc_o(crc), .done_o(done), .mismatch_o(mm)
  );

  crc8_serial_chk #(.FRAME_BITS(72)) dut72 (
    .clk(clk), .rst(rst), .sof_i(sof), .bit_vld_i(vld), .bit_i(din),
    .exp_vld_i(expv), .exp_crc_i(expc),
    .crc_o(crc72), .done_o(done72), .mismatch_o(mm72)
  );

  // row: data[41:10], expected crc[9:2], exp supplied[1], corrupt exp[0]
  localparam logic [41:0] VEC [6] = '{
    {32'h0000_0000, 8'h00, 1'b1, 1'b0},
    {32'h0000_0001, 8'h07, 1'b1, 1'b0},
    {32'h0000_0080, 8'h89, 1'b1, 1'b1},
    {32'h0000_0100, 8'h15, 1'b0, 1'b1},
    {32'h0000_0101, 8'h12, 1'b1, 1'b1},
    {32'h0000_0181, 8'h9B, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp_v);
    end
  endtask

  // byte-wise reference, independent of the bit-serial structure
  function automatic logic [7:0] ref_crc(input logic [71:0] d, input int nbits);
    logic [7:0] c = 8'h00;
    for (int b = nbits / 8 - 1; b >= 0; b--) begin
      c = c ^ d[b*8 +: 8];
      for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  task automatic send_frame(input logic [71:0] data, input int nbits, input int gap, input bit sof_with_bit);
    if (!sof_with_bit) begin
      @(negedge clk); sof = 1'b1; vld = 1'b0;
    end
    for (int i = nbits - 1; i >= 0; i--) begin
      @(negedge clk); sof = sof_with_bit && (i == nbits - 1); vld = 1'b1; din = data[i];
      if (gap > 0 && i > 0)
        for (int g = 0; g < gap; g++) begin
          @(negedge clk); sof = 1'b0; vld = 1'b0; din = ~din;
        end
    end
    @(negedge clk); sof = 1'b0; vld = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    check(crc == 8'h00 && !done && !mm, "R1 reset", {crc, done, mm}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(crc == 8'h00 && !done && !mm, "R1 after reset", {crc, done, mm}, 0);

    // table walk: R2 values, R5 strobe timing, R6 compare
    foreach (VEC[v]) begin
      logic [31:0] d = VEC[v][41:10];
      logic [7:0]  e = VEC[v][9:2];
      expv = VEC[v][1];
      expc = VEC[v][0] ? (e ^ 8'h5A) : e;
      send_frame({40'h0, d}, 32, 0, 1'b0);
      check(crc == e, "R2 table crc", crc, e);
      check(ref_crc({40'h0, d}, 32) == e, "R2 reference agrees", ref_crc({40'h0, d}, 32), e);
      check(done == 1'b1, "R5 done strobe", done, 1);
      check(mm == (VEC[v][1] & VEC[v][0]), "R6 mismatch", mm, VEC[v][1] & VEC[v][0]);
      held = crc;
      @(negedge clk);
      check(done == 1'b0, "R5 done one cycle", done, 0);
      check(mm == 1'b0, "R6 mismatch drops with done", mm, 0);
      check(crc == held, "R5 crc held", crc, held);
    end
    expv = 1'b0;

    // R4: idle gaps do not alter result
    send_frame(72'h100, 32, 2, 1'b0);
    check(crc == 8'h15 && done, "R4 gaps ignored", crc, 8'h15);

    // R7: bits with no open frame ignored
    held = crc;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); vld = 1'b1; din = i[0];
    end
    @(negedge clk); vld = 1'b0;
    check(crc == held, "R7 stray bits crc", crc, held);
    check(done == 1'b0, "R7 stray bits no done", done, 0);

    // R3: lone start clears register, mid-frame restart
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    check(crc == 8'h00, "R3 start clears", crc, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); vld = 1'b1; din = 1'b1;
    end
    @(negedge clk); vld = 1'b0;
    check(crc != 8'h00 && !done, "R3 partial frame busy", crc, 1);
    send_frame(72'h1, 32, 0, 1'b0);
    check(crc == 8'h07 && done, "R3 restart result", crc, 8'h07);

    // R9: start with first bit in the same cycle
    send_frame(72'h8000_0001, 32, 0, 1'b1);
    check(crc == ref_crc(72'h8000_0001, 32) && done, "R9 start with bit",
          crc, ref_crc(72'h8000_0001, 32));

    // R8: 72-bit frame of the check string
    send_frame("123456789", 72, 0, 1'b0);
    check(crc72 == 8'hF4, "R8 check string", crc72, 8'hF4);
    check(done72 == 1'b1, "R8 done at 72 bits", done72, 1);

    // R1: reset mid-frame returns to idle values
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0; vld = 1'b1; din = 1'b1;
    @(negedge clk); vld = 1'b0; rst = 1'b1;
    @(negedge clk);
    check(crc == 8'h00 && !done && !mm, "R1 reset mid-frame", {crc, done, mm}, 0);
    rst = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule